// File: doc/BRIEF.md
# Dual-Side Integrator Conversion Sequencer

This block is the control sequencer for a converter front end that has two charge integrators, called side A and side B. An external CONV level marks the integration boundaries. On every full CONV period one side integrates. After that period, a measure/reset/auto-zero (MRZ) engine measures that side and prepares it again. The next integration then goes to the other side. CONV is asynchronous, so it passes through a synchronizer before the state logic uses it. The MRZ engine answers each start pulse with a synchronous busy flag.

The sequencer has eight working states plus an idle state. While an MRZ cycle is busy, CONV has no effect. For that reason, CONV waveforms that differ only inside the busy window give exactly the same state trace. The preparation state that follows an MRZ cycle ends as soon as CONV reaches its active level, so the sequencer itself sets no minimum time there. Instead, a separate monitor measures each preparation phase against a programmable limit. It raises a sticky flag when a phase is too short. Software clears that flag with a one-cycle pulse.

Top module: `twin_integ_seq`

## Requirements
- R1: While `rst_n` is sampled low, and after reset until the first CONV edge, `seq_state` is 0 (idle) and `int_active`, `mrz_start`, `data_valid` and `prep_violation` are 0. CONV edges seen in the first SYNC_STAGES+1 cycles after reset are ignored.
- R2: From idle, the first synchronized CONV edge decides the path and the first side. A rising edge moves to state 3 with `int_side`=0 (side A). A falling edge moves to state 6 with `int_side`=1 (side B). The state changes on the third rising clock edge after CONV changes: two synchronizer stages plus the state register.
- R3: The rising path runs 3 →(CONV low) 4 →(CONV high) 1 →(MRZ done) 2 →(CONV high) 3. The falling path runs 6 →(CONV high) 5 →(CONV low) 8 →(MRZ done) 7 →(CONV low) 6. `int_active` is 1 exactly in states 3, 4, 5 and 6. `int_side` (0=A, 1=B) changes to the other side after every MRZ entry.
- R4: `mrz_start` is a one-cycle pulse in the first cycle of state 1 or state 8. The sequencer leaves state 1 or 8 only after `mrz_busy` has been seen high and then seen low.
- R5: While `mrz_busy` is high in state 1 or 8, the state does not change, whatever CONV does. Two CONV waveforms that differ only inside the busy windows produce identical state traces, cycle for cycle.
- R6: State 2 is left on the first cycle in which the synchronized CONV is high, and state 7 on the first cycle in which it is low. There is no minimum stay. With CONV as a square wave of half-period H, and busy lasting L cycles, the preparation state lasts 2H−L−1 cycles.
- R7: `data_valid` is a one-cycle strobe in the first cycle of state 2 or state 7. `data_side` names the side just measured (0=A, 1=B). The strobe has no ready input and cannot be held back.
- R8: When state 2 or 7 is left after d cycles, `prep_violation` is set if d < `min_prep`. A stay of exactly `min_prep` cycles does not set it.
- R9: `prep_violation` stays set until `viol_clr` is sampled high. If a new violation and a clear happen in the same cycle, the violation wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv | input | 1 | Asynchronous CONV level; it marks integration boundaries |
| mrz_busy | input | 1 | Synchronous busy flag from the MRZ engine |
| min_prep | input | PREP_W | Minimum preparation time in clock cycles |
| viol_clr | input | 1 | One-cycle clear for the sticky violation flag |
| seq_state | output | 4 | State code: 0 idle, 1 to 8 sequence states |
| int_active | output | 1 | A side is integrating (states 3, 4, 5, 6) |
| int_side | output | 1 | Integrating or next side, 0=A, 1=B |
| mrz_start | output | 1 | One-cycle start pulse for the MRZ engine |
| data_valid | output | 1 | One-cycle strobe: a side has been measured |
| data_side | output | 1 | Side named by `data_valid`, 0=A, 1=B |
| prep_violation | output | 1 | Sticky flag: a preparation phase was too short |

## Verification
The bench first drives a 50% square wave with H=810, started from the rising edge, and checks the 3-4-1-2 loop, the side alternation and the 619-cycle preparation stays. It then drives a second waveform that pulses CONV several times inside each busy window. That trace must match the first one cycle for cycle, which shows that CONV is ignored during MRZ. A square wave with H=1521 and a long busy cycle leaves 18-cycle preparation phases. With `min_prep` at 18 and then 19, this separates the non-violating boundary from a real violation, and the bench also checks the sticky clear. A run started from a falling edge with CONV held high through reset covers the mirrored 6-5-8-7 path, the side-B start and the warm-up filter after reset.

// File: rtl/twin_integ_pkg.sv
package twin_integ_pkg;

  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_MRZ_R   = 4'd1,
    ST_PREP_R  = 4'd2,
    ST_RISE_HI = 4'd3,
    ST_RISE_LO = 4'd4,
    ST_FALL_HI = 4'd5,
    ST_FALL_LO = 4'd6,
    ST_PREP_F  = 4'd7,
    ST_MRZ_F   = 4'd8
  } seq_state_e;

  localparam logic SIDE_A = 1'b0;
  localparam logic SIDE_B = 1'b1;

endpackage

// File: rtl/twin_integ_sync.sv
module twin_integ_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out,
  output logic sync_prev,
  output logic armed
);

  localparam int WARM = STAGES + 1;
  localparam int WW   = $clog2(WARM + 1);

  logic [STAGES-1:0] chain_q;
  logic [WW-1:0]     warm_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_prev <= 1'b0;
      warm_q    <= '0;
    end else begin
      sync_prev <= chain_q[STAGES-1];
      if (warm_q != WW'(WARM)) warm_q <= warm_q + 1'b1;
    end
  end

  assign sync_out = chain_q[STAGES-1];
  assign armed    = (warm_q == WW'(WARM));

endmodule

// File: rtl/twin_integ_fsm.sv
module twin_integ_fsm
  import twin_integ_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       conv_s,
  input  logic       conv_prev,
  input  logic       armed,
  input  logic       busy,
  output seq_state_e state,
  output logic       cur_side,
  output logic       meas_side,
  output logic       mrz_start,
  output logic       data_valid,
  output logic       in_prep,
  output logic       prep_exit
);

  seq_state_e state_q, state_d;
  logic busy_seen_q;
  logic in_mrz, mrz_done, mrz_enter, mrz_leave;

  assign in_mrz   = (state_q == ST_MRZ_R) || (state_q == ST_MRZ_F);
  assign mrz_done = busy_seen_q && !busy;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (armed && (conv_s != conv_prev))
                    state_d = conv_s ? ST_RISE_HI : ST_FALL_LO;
      ST_RISE_HI: if (!conv_s)  state_d = ST_RISE_LO;
      ST_RISE_LO: if (conv_s)   state_d = ST_MRZ_R;
      ST_MRZ_R:   if (mrz_done) state_d = ST_PREP_R;
      ST_PREP_R:  if (conv_s)   state_d = ST_RISE_HI;
      ST_FALL_LO: if (conv_s)   state_d = ST_FALL_HI;
      ST_FALL_HI: if (!conv_s)  state_d = ST_MRZ_F;
      ST_MRZ_F:   if (mrz_done) state_d = ST_PREP_F;
      ST_PREP_F:  if (!conv_s)  state_d = ST_FALL_LO;
      default:    state_d = ST_IDLE;
    endcase
  end

  assign mrz_enter = ((state_d == ST_MRZ_R) || (state_d == ST_MRZ_F)) && !in_mrz;
  assign mrz_leave = in_mrz && (state_d != state_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cur_side    <= SIDE_A;
      meas_side   <= SIDE_A;
      busy_seen_q <= 1'b0;
      mrz_start   <= 1'b0;
      data_valid  <= 1'b0;
    end else begin
      state_q    <= state_d;
      mrz_start  <= mrz_enter;
      data_valid <= mrz_leave;
      if ((state_q == ST_IDLE) && (state_d != ST_IDLE)) begin
        cur_side <= conv_s ? SIDE_A : SIDE_B;
      end else if (mrz_enter) begin
        meas_side <= cur_side;
        cur_side  <= ~cur_side;
      end
      if (mrz_enter)             busy_seen_q <= 1'b0;
      else if (in_mrz && busy)   busy_seen_q <= 1'b1;
    end
  end

  assign state     = state_q;
  assign in_prep   = (state_q == ST_PREP_R) || (state_q == ST_PREP_F);
  assign prep_exit = in_prep && (state_d != state_q);

endmodule

// File: rtl/twin_integ_prepmon.sv
module twin_integ_prepmon #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_prep,
  input  logic         prep_exit,
  input  logic [W-1:0] min_prep,
  input  logic         clr,
  output logic         viol
);

  logic [W-1:0] cnt_q;
  logic [W:0]   stay;
  logic         short_stay;

  assign stay       = {1'b0, cnt_q} + (W+1)'(1);
  assign short_stay = prep_exit && (stay < {1'b0, min_prep});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      viol  <= 1'b0;
    end else begin
      if (!in_prep)        cnt_q <= '0;
      else if (~&cnt_q)    cnt_q <= cnt_q + 1'b1;
      if (short_stay)      viol <= 1'b1;
      else if (clr)        viol <= 1'b0;
    end
  end

endmodule

// File: rtl/twin_integ_seq.sv
module twin_integ_seq
  import twin_integ_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PREP_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv,
  input  logic              mrz_busy,
  input  logic [PREP_W-1:0] min_prep,
  input  logic              viol_clr,
  output logic [3:0]        seq_state,
  output logic              int_active,
  output logic              int_side,
  output logic              mrz_start,
  output logic              data_valid,
  output logic              data_side,
  output logic              prep_violation
);

  logic       conv_s, conv_prev, armed;
  seq_state_e st;
  logic       in_prep, prep_exit;

  twin_integ_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .async_in  (conv),
    .sync_out  (conv_s),
    .sync_prev (conv_prev),
    .armed     (armed)
  );

  twin_integ_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_s     (conv_s),
    .conv_prev  (conv_prev),
    .armed      (armed),
    .busy       (mrz_busy),
    .state      (st),
    .cur_side   (int_side),
    .meas_side  (data_side),
    .mrz_start  (mrz_start),
    .data_valid (data_valid),
    .in_prep    (in_prep),
    .prep_exit  (prep_exit)
  );

  twin_integ_prepmon #(.W(PREP_W)) u_prep (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_prep   (in_prep),
    .prep_exit (prep_exit),
    .min_prep  (min_prep),
    .clr       (viol_clr),
    .viol      (prep_violation)
  );

  assign seq_state  = st;
  assign int_active = (st == ST_RISE_HI) || (st == ST_RISE_LO) ||
                      (st == ST_FALL_HI) || (st == ST_FALL_LO);

endmodule

// File: rtl/twin_integ_seq_chk.sv
module twin_integ_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       conv_s,
  input logic       mrz_busy,
  input logic       viol_clr,
  input logic [3:0] seq_state,
  input logic       mrz_start,
  input logic       data_valid,
  input logic       prep_violation
);

  // R4
  mrz_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrz_start |-> ((seq_state == 4'd1) || (seq_state == 4'd8)) &&
                  ($past(seq_state) != seq_state));

  // R4
  mrz_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrz_start |=> !mrz_start);

  // R5
  busy_hold_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((seq_state == 4'd1) && mrz_busy) |=> (seq_state == 4'd1));

  // R5
  busy_hold_f_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((seq_state == 4'd8) && mrz_busy) |=> (seq_state == 4'd8));

  // R6
  prep_r_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((seq_state == 4'd2) && !conv_s) |=> (seq_state == 4'd2));

  // R6
  prep_f_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((seq_state == 4'd7) && conv_s) |=> (seq_state == 4'd7));

  // R7
  dv_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> ((seq_state == 4'd2) || (seq_state == 4'd7)) &&
                   (($past(seq_state) == 4'd1) || ($past(seq_state) == 4'd8)));

  // R9
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prep_violation && !viol_clr) |=> prep_violation);

endmodule

bind twin_integ_seq twin_integ_seq_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .conv_s         (conv_s),
  .mrz_busy       (mrz_busy),
  .viol_clr       (viol_clr),
  .seq_state      (seq_state),
  .mrz_start      (mrz_start),
  .data_valid     (data_valid),
  .prep_violation (prep_violation)
);

// File: tb/twin_integ_seq_tb_top.sv
module twin_integ_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv = 1'b0;
  logic        mrz_busy;
  logic [15:0] min_prep = 16'd100;
  logic        viol_clr = 1'b0;
  logic [3:0]  seq_state;
  logic        int_active, int_side, mrz_start, data_valid, data_side, prep_violation;

  always #2 clk = ~clk;

  twin_integ_seq dut_i (
    .clk(clk), .rst_n(rst_n), .conv(conv), .mrz_busy(mrz_busy),
    .min_prep(min_prep), .viol_clr(viol_clr), .seq_state(seq_state),
    .int_active(int_active), .int_side(int_side), .mrz_start(mrz_start),
    .data_valid(data_valid), .data_side(data_side), .prep_violation(prep_violation)
  );

  typedef struct { int st; int side; } exp_t;
  exp_t exp_q[$];
  int   dv_q[$];

  int n_tests = 0, n_fail = 0;
  int busy_len = 1000;
  int cyc = 0, t0 = 0;
  int mon_on = 0, prev_st = 0, prep_len = 0, last_prep = -1, rec = 0;
  int trace_n [2];
  int tr_cyc [2][32];
  int tr_st  [2][32];

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  // MRZ engine model: busy rises one clock after the start pulse
  initial begin
    mrz_busy = 1'b0;
    forever begin
      @(posedge clk); #1;
      if (mrz_start) begin
        mrz_busy = 1'b1;
        repeat (busy_len) @(posedge clk);
        #1 mrz_busy = 1'b0;
      end
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops expected items on each state change
  initial begin
    exp_t e;
    int   s;
    forever begin
      @(negedge clk);
      if (mon_on != 0) begin
        if (int'(seq_state) != prev_st) begin
          if (trace_n[rec] < 32) begin
            tr_cyc[rec][trace_n[rec]] = cyc - t0;
            tr_st[rec][trace_n[rec]]  = int'(seq_state);
            trace_n[rec]++;
          end
          if (exp_q.size() == 0) begin
            chk(1'b0, "R3 unexpected state", int'(seq_state), -1);
          end else begin
            e = exp_q.pop_front();
            chk(int'(seq_state) == e.st, "R3 state order", int'(seq_state), e.st);
            if (e.st >= 3 && e.st <= 6)
              chk(int_active && (int'(int_side) == e.side), "R3 integrating side",
                  2*int'(int_active) + int'(int_side), 2 + e.side);
            else
              chk(!int_active, "R3 no integration", int'(int_active), 0);
          end
          if (seq_state == 4'd1 || seq_state == 4'd8)
            chk(mrz_start == 1'b1, "R4 mrz_start on entry", int'(mrz_start), 1);
          if (seq_state == 4'd2 || seq_state == 4'd7) begin
            chk(data_valid == 1'b1, "R7 data_valid strobe", int'(data_valid), 1);
            if (dv_q.size() != 0) begin
              s = dv_q.pop_front();
              chk(int'(data_side) == s, "R7 data_side", int'(data_side), s);
            end
          end
          if (prev_st == 2 || prev_st == 7) last_prep = prep_len;
          prep_len = 0;
        end
        if (seq_state == 4'd2 || seq_state == 4'd7) prep_len++;
        prev_st = int'(seq_state);
      end
    end
  end

  task automatic run_seq(input bit inv, input int h, input int nper, input bit glitch, input int slot);
    mon_on = 0;
    rst_n = 1'b0; conv = inv; viol_clr = 1'b0;
    repeat (4) @(negedge clk);
    chk(seq_state == 4'd0 && !int_active && !mrz_start && !data_valid && !prep_violation,
        "R1 reset state", int'(seq_state) + int'(prep_violation) + int'(data_valid), 0);
    rst_n = 1'b1;
    exp_q.delete(); dv_q.delete();
    rec = slot; trace_n[slot] = 0; prev_st = 0; last_prep = -1; prep_len = 0;
    repeat (8) @(negedge clk);
    chk(seq_state == 4'd0, "R1 idle before first edge", int'(seq_state), 0);
    t0 = cyc; mon_on = 1;
    for (int k = 0; k < nper; k++) begin
      int sd;
      sd = int'(inv) ^ ((k / 2) % 2);
      conv = !inv;
      if (k % 2 == 0) begin
        exp_q.push_back(exp_t'{inv ? 6 : 3, sd});
        repeat (h) @(negedge clk);
        conv = inv;
        exp_q.push_back(exp_t'{inv ? 5 : 4, sd});
        repeat (h) @(negedge clk);
      end else begin
        exp_q.push_back(exp_t'{inv ? 8 : 1, 0});
        exp_q.push_back(exp_t'{inv ? 7 : 2, 0});
        dv_q.push_back(sd);
        if (glitch) begin
          repeat (300) @(negedge clk); conv = inv;
          repeat (200) @(negedge clk); conv = !inv;
          repeat (200) @(negedge clk); conv = inv;
          repeat (2*h - 700) @(negedge clk);
        end else begin
          repeat (h) @(negedge clk); conv = inv;
          repeat (h) @(negedge clk);
        end
      end
    end
    repeat (12) @(negedge clk);
    mon_on = 0;
    chk(exp_q.size() == 0, "R3 all expected states seen", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int mism;
    // Square wave, rising start, H=810, busy 1000
    busy_len = 1000; min_prep = 16'd100;
    run_seq(1'b0, 810, 6, 1'b0, 0);
    chk(tr_st[0][0] == 3 && tr_cyc[0][0] == 3, "R2 rising start latency", tr_cyc[0][0], 3);
    chk(last_prep == 619, "R6 prep stay length", last_prep, 619);
    chk(prep_violation == 1'b0, "R8 long prep no violation", int'(prep_violation), 0);

    // Same loop with CONV pulses inside busy windows
    run_seq(1'b0, 810, 6, 1'b1, 1);
    chk(trace_n[0] == trace_n[1], "R5 trace length equal", trace_n[1], trace_n[0]);
    mism = 0;
    for (int i = 0; i < 32; i++)
      if (i < trace_n[0] && (tr_cyc[0][i] != tr_cyc[1][i] || tr_st[0][i] != tr_st[1][i])) mism++;
    chk(mism == 0, "R5 identical traces", mism, 0);

    // Long period, short prep: boundary at 18 cycles
    busy_len = 3023; min_prep = 16'd18;
    run_seq(1'b0, 1521, 6, 1'b0, 0);
    chk(last_prep == 18, "R6 short prep no minimum", last_prep, 18);
    chk(prep_violation == 1'b0, "R8 stay equal to limit", int'(prep_violation), 0);

    min_prep = 16'd19;
    run_seq(1'b0, 1521, 6, 1'b0, 0);
    chk(prep_violation == 1'b1, "R8 too-short prep flagged", int'(prep_violation), 1);
    repeat (5) @(negedge clk);
    chk(prep_violation == 1'b1, "R9 flag sticky", int'(prep_violation), 1);
    viol_clr = 1'b1;
    @(negedge clk);
    viol_clr = 1'b0;
    chk(prep_violation == 1'b0, "R9 flag cleared", int'(prep_violation), 0);

    // Mirrored path: CONV high through reset, falling start
    busy_len = 1000; min_prep = 16'd100;
    run_seq(1'b1, 810, 6, 1'b0, 0);
    chk(tr_st[0][0] == 6 && tr_cyc[0][0] == 3, "R2 falling start latency", tr_st[0][0], 6);
    chk(last_prep == 619, "R6 state 7 leaves on CONV low", last_prep, 619);
    chk(prep_violation == 1'b0, "R8 mirrored no violation", int'(prep_violation), 0);

    finish_run();
  end

endmodule